// File: doc/BRIEF.md
# Dependency-Aware Memory Request Scheduler

This block sits between a group of processor cores and a single DRAM bank. It keeps a fixed pool of pending load and store requests and chooses one of them each cycle to hand to the memory. The pool is split into equal partitions, one per core. Each core has its own insert port that writes only into its partition, so every core can post a request in the same cycle without contending for a shared write path.

Every stored request carries a bitmap with one bit per pool slot, naming the older requests it must wait for. These bits are set when the request is inserted and cleared when the named request leaves. Among the requests with an empty bitmap, a single combinational pick chooses the winner on a key. The key ranks a load served by forwarding from a pending store first, then a request to the row the bank currently has open, then the request that has waited longest.

Each core owns a fixed slice of the address space, chosen by the top address bits. A request outside that slice is refused and flagged in the same cycle. The memory side sees the chosen request combinationally and confirms it with a ready strobe. The confirmed entry leaves the pool at that clock edge.

Top module: `mrs_sched`

## Requirements
- R1: After reset the pool is empty: `issue_valid` is 0 and every bit of `ins_full` is 0.
- R2: Core c's requests go only into slots c*SLOTS to c*SLOTS+SLOTS-1, always into the lowest-numbered free slot of that range. All cores may insert in the same cycle.
- R3: A request from core c is in range only when its top log2(NCORES) address bits equal c. An out-of-range request raises `ins_err[c]` in the same cycle and is not stored.
- R4: `ins_full[c]` is 1 exactly when every slot of core c's partition holds a request. A request posted while the partition is full is dropped.
- R5: A new request waits for an older entry of its own core when both use the same address and either one is a store. It also waits when the older entry is a load whose register equals the new request's register. An entry that is leaving in the insert cycle creates no wait.
- R6: Only an entry with an all-zero wait bitmap may be issued. When an issued entry leaves, its slot becomes free and its bit is cleared in every other entry's bitmap.
- R7: Among eligible entries, the winner has the largest key {forwarded, row hit, age}. Ties go to the lowest slot number.
- R8: A load inserted while its core has a pending store to the same address is marked forwarded. It takes the data of the youngest such store (smallest age, lowest slot on a tie) and does not wait on those stores. `issue_fwd` and `issue_data` present this on issue.
- R9: An entry is a row hit when `open_valid` is 1 and its address bits [ADDR_W-1:ROW_LSB] equal `open_row`. This is evaluated anew every cycle.
- R10: Selection is combinational from stored state. A request inserted at an edge can be issued from the following cycle. The entry leaves at the edge where `issue_valid` and `issue_ready` are both 1. `issue_store`, `issue_id` and `issue_reg` show the stored fields of the chosen slot.
- R11: An entry's age is 0 in its first cycle. It rises by one per cycle and saturates at 2^AGE_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | NCORES | Per-core request strobe |
| ins_store | input | NCORES | Per-core request is a store (1) or load (0) |
| ins_reg | input | NCORES x REG_W | Per-core register: load destination or store source |
| ins_addr | input | NCORES x ADDR_W | Per-core word address |
| ins_id | input | NCORES x ID_W | Per-core request tag |
| ins_data | input | NCORES x DATA_W | Per-core store data |
| ins_full | output | NCORES | Partition has no free slot |
| ins_err | output | NCORES | Request address outside the core's slice |
| open_valid | input | 1 | DRAM bank has an open row |
| open_row | input | ADDR_W-ROW_LSB | Currently open row |
| issue_valid | output | 1 | An eligible request is presented |
| issue_ready | input | 1 | DRAM takes the presented request |
| issue_slot | output | log2(DEPTH) | Pool slot of the presented request |
| issue_store | output | 1 | Presented request is a store |
| issue_fwd | output | 1 | Presented load is served by forwarding |
| issue_reg | output | REG_W | Register field of the presented request |
| issue_addr | output | ADDR_W | Address of the presented request |
| issue_id | output | ID_W | Tag of the presented request |
| issue_data | output | DATA_W | Store data or forwarded load data |

## Verification
The assertions assume that NCORES is a power of two and that the memory side only raises `issue_ready` as a plain strobe, with no other demand on its timing. The stimulus draws addresses from a few rows and columns per core, so same-address and same-register collisions are frequent. It sends about one request in ten outside the sender's slice. The open row and the ready strobe change at random, and a directed phase holds entries long enough for their ages to saturate.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int KEY_AGE_W = 32;

  // Packed selection key: forwarded flag above row-hit above age.
  function automatic logic [KEY_AGE_W+1:0] mk_key(input logic fwd, input logic hit,
                                                  input logic [KEY_AGE_W-1:0] age);
    return {fwd, hit, age};
  endfunction

  // Bank row number carried in the upper address bits.
  function automatic logic [31:0] row_of(input logic [31:0] addr, input int lsb);
    return addr >> lsb;
  endfunction
endpackage

// File: rtl/mrs_insert.sv
module mrs_insert #(
  parameter int CORE    = 0,
  parameter int NCORES  = 4,
  parameter int SLOTS   = 8,
  parameter int ADDR_W  = 16,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int AGE_W   = 8
) (
  input  logic                          req_valid,
  input  logic                          req_store,
  input  logic [REG_W-1:0]              req_reg,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_data,
  input  logic [SLOTS-1:0]              v,
  input  logic [SLOTS-1:0]              st,
  input  logic [SLOTS-1:0][REG_W-1:0]   rg,
  input  logic [SLOTS-1:0][ADDR_W-1:0]  ad,
  input  logic [SLOTS-1:0][DATA_W-1:0]  dt,
  input  logic [SLOTS-1:0][AGE_W-1:0]   age,
  input  logic [SLOTS-1:0]              leaving,
  output logic                          take,
  output logic [(SLOTS>1?$clog2(SLOTS):1)-1:0] lslot,
  output logic [SLOTS-1:0]              ldep,
  output logic                          fwd,
  output logic [DATA_W-1:0]             fdata,
  output logic                          full,
  output logic                          err
);
  localparam int CORE_W = $clog2(NCORES);
  localparam int LIDX_W = SLOTS > 1 ? $clog2(SLOTS) : 1;

  logic             in_range;
  logic             found;
  logic [AGE_W-1:0] best_age;
  logic             same_addr, reg_haz, addr_haz;

  assign in_range = req_addr[ADDR_W-1 -: CORE_W] == CORE_W'(CORE);
  assign err      = req_valid && !in_range;
  assign take     = req_valid && in_range && !full;

  // Lowest free slot of this partition.
  always_comb begin
    full  = 1'b1;
    found = 1'b0;
    lslot = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!v[k]) begin
        full = 1'b0;
        if (!found) begin
          found = 1'b1;
          lslot = LIDX_W'(k);
        end
      end
    end
  end

  // Youngest pending store to the same address supplies a load.
  always_comb begin
    fwd      = 1'b0;
    best_age = '1;
    fdata    = req_data;
    for (int k = 0; k < SLOTS; k++) begin
      if (v[k] && st[k] && !req_store && ad[k] == req_addr &&
          (!fwd || age[k] < best_age)) begin
        fwd      = 1'b1;
        best_age = age[k];
        fdata    = dt[k];
      end
    end
  end

  // Wait bitmap against every older entry of the same core.
  always_comb begin
    ldep      = '0;
    same_addr = 1'b0;
    reg_haz   = 1'b0;
    addr_haz  = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      same_addr = ad[k] == req_addr;
      reg_haz   = !st[k] && rg[k] == req_reg;
      addr_haz  = same_addr && (req_store || st[k]) && !fwd;
      ldep[k]   = v[k] && !leaving[k] && (reg_haz || addr_haz);
    end
  end
endmodule

// File: rtl/mrs_select.sv
module mrs_select
  import mrs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AGE_W = 8
) (
  input  logic [DEPTH-1:0]              v,
  input  logic [DEPTH-1:0][DEPTH-1:0]   dep,
  input  logic [DEPTH-1:0]              fw,
  input  logic [DEPTH-1:0]              hit,
  input  logic [DEPTH-1:0][AGE_W-1:0]   age,
  output logic                          any,
  output logic [$clog2(DEPTH)-1:0]      win
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]       elig;
  logic [KEY_AGE_W+1:0]   key, best;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) elig[i] = v[i] && (dep[i] == '0);
  end

  // Strict compare in ascending order keeps the lowest slot on ties.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    key  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      key = mk_key(fw[i], hit[i], KEY_AGE_W'(age[i]));
      if (elig[i] && (!any || key > best)) begin
        any  = 1'b1;
        best = key;
        win  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mrs_sched.sv
module mrs_sched
  import mrs_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int SLOTS   = 8,
  parameter int ADDR_W  = 16,
  parameter int ROW_LSB = 8,
  parameter int REG_W   = 5,
  parameter int ID_W    = 6,
  parameter int DATA_W  = 32,
  parameter int AGE_W   = 8,
  localparam int DEPTH  = NCORES * SLOTS,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ROW_W  = ADDR_W - ROW_LSB
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCORES-1:0]              ins_valid,
  input  logic [NCORES-1:0]              ins_store,
  input  logic [NCORES-1:0][REG_W-1:0]   ins_reg,
  input  logic [NCORES-1:0][ADDR_W-1:0]  ins_addr,
  input  logic [NCORES-1:0][ID_W-1:0]    ins_id,
  input  logic [NCORES-1:0][DATA_W-1:0]  ins_data,
  output logic [NCORES-1:0]              ins_full,
  output logic [NCORES-1:0]              ins_err,
  input  logic                           open_valid,
  input  logic [ROW_W-1:0]               open_row,
  output logic                           issue_valid,
  input  logic                           issue_ready,
  output logic [IDX_W-1:0]               issue_slot,
  output logic                           issue_store,
  output logic                           issue_fwd,
  output logic [REG_W-1:0]               issue_reg,
  output logic [ADDR_W-1:0]              issue_addr,
  output logic [ID_W-1:0]                issue_id,
  output logic [DATA_W-1:0]              issue_data
);
  localparam int LIDX_W = SLOTS > 1 ? $clog2(SLOTS) : 1;

  // Pool state
  logic [DEPTH-1:0]              v_q, st_q, fw_q;
  logic [DEPTH-1:0][REG_W-1:0]   rg_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  ad_q;
  logic [DEPTH-1:0][ID_W-1:0]    id_q;
  logic [DEPTH-1:0][DATA_W-1:0]  dt_q;
  logic [DEPTH-1:0][DEPTH-1:0]   dep_q;
  logic [DEPTH-1:0][AGE_W-1:0]   age_q;

  // Named internal events
  logic [DEPTH-1:0]              row_hit;
  logic                          sel_any;
  logic [IDX_W-1:0]              sel_win;
  logic                          fire;
  logic [DEPTH-1:0]              leave_mask;

  logic [NCORES-1:0]             take, nfw;
  logic [NCORES-1:0][LIDX_W-1:0] lslot;
  logic [NCORES-1:0][IDX_W-1:0]  nslot;
  logic [NCORES-1:0][SLOTS-1:0]  ldep;
  logic [NCORES-1:0][DEPTH-1:0]  ndep;
  logic [NCORES-1:0][DATA_W-1:0] ndata;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      row_hit[i] = open_valid &&
                   ROW_W'(row_of(32'(ad_q[i]), ROW_LSB)) == open_row;
  end

  assign fire       = sel_any && issue_ready;
  assign leave_mask = fire ? (DEPTH'(1) << sel_win) : '0;

  genvar c;
  generate
    for (c = 0; c < NCORES; c++) begin : g_core
      mrs_insert #(
        .CORE(c), .NCORES(NCORES), .SLOTS(SLOTS), .ADDR_W(ADDR_W),
        .REG_W(REG_W), .DATA_W(DATA_W), .AGE_W(AGE_W)
      ) u_ins (
        .req_valid (ins_valid[c]),
        .req_store (ins_store[c]),
        .req_reg   (ins_reg[c]),
        .req_addr  (ins_addr[c]),
        .req_data  (ins_data[c]),
        .v         (v_q[c*SLOTS +: SLOTS]),
        .st        (st_q[c*SLOTS +: SLOTS]),
        .rg        (rg_q[c*SLOTS +: SLOTS]),
        .ad        (ad_q[c*SLOTS +: SLOTS]),
        .dt        (dt_q[c*SLOTS +: SLOTS]),
        .age       (age_q[c*SLOTS +: SLOTS]),
        .leaving   (leave_mask[c*SLOTS +: SLOTS]),
        .take      (take[c]),
        .lslot     (lslot[c]),
        .ldep      (ldep[c]),
        .fwd       (nfw[c]),
        .fdata     (ndata[c]),
        .full      (ins_full[c]),
        .err       (ins_err[c])
      );
      assign nslot[c] = IDX_W'(c * SLOTS) + IDX_W'(lslot[c]);
      assign ndep[c]  = DEPTH'(ldep[c]) << (c * SLOTS);

      a_r3_err_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        ins_err[c] |=> $countones(v_q[c*SLOTS +: SLOTS]) <= $past($countones(v_q[c*SLOTS +: SLOTS])));
      a_r4_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        ins_full[c] |=> $countones(v_q[c*SLOTS +: SLOTS]) <= $past($countones(v_q[c*SLOTS +: SLOTS])));
    end
  endgenerate

  mrs_select #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_sel (
    .v   (v_q),
    .dep (dep_q),
    .fw  (fw_q),
    .hit (row_hit),
    .age (age_q),
    .any (sel_any),
    .win (sel_win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      st_q  <= '0;
      fw_q  <= '0;
      rg_q  <= '0;
      ad_q  <= '0;
      id_q  <= '0;
      dt_q  <= '0;
      dep_q <= '0;
      age_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (v_q[i] && age_q[i] != {AGE_W{1'b1}}) age_q[i] <= age_q[i] + 1'b1;
      if (fire) begin
        v_q[sel_win] <= 1'b0;
        for (int j = 0; j < DEPTH; j++) dep_q[j][sel_win] <= 1'b0;
      end
      for (int k = 0; k < NCORES; k++) begin
        if (take[k]) begin
          v_q[nslot[k]]   <= 1'b1;
          st_q[nslot[k]]  <= ins_store[k];
          fw_q[nslot[k]]  <= nfw[k];
          rg_q[nslot[k]]  <= ins_reg[k];
          ad_q[nslot[k]]  <= ins_addr[k];
          id_q[nslot[k]]  <= ins_id[k];
          dt_q[nslot[k]]  <= ndata[k];
          dep_q[nslot[k]] <= ndep[k];
          age_q[nslot[k]] <= '0;
        end
      end
    end
  end

  assign issue_valid = sel_any;
  assign issue_slot  = sel_win;
  assign issue_store = st_q[sel_win];
  assign issue_fwd   = fw_q[sel_win];
  assign issue_reg   = rg_q[sel_win];
  assign issue_addr  = ad_q[sel_win];
  assign issue_id    = id_q[sel_win];
  assign issue_data  = dt_q[sel_win];

  // Observation signals for the assertions
  logic [DEPTH-1:0] no_wait, col_any;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      no_wait[i] = ~|dep_q[i];
      col_any[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) col_any[i] = col_any[i] | dep_q[j][i];
    end
  end

  a_r6_issue_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> v_q[issue_slot] && no_wait[issue_slot]);
  a_r8_fwd_first: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_fwd |-> (v_q & fw_q & no_wait) == '0);
  a_r6_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !v_q[$past(issue_slot)]);
  a_r6_wait_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !col_any[$past(issue_slot)]);
  a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    v_q == '0 |-> !issue_valid);
endmodule

// File: tb/test_mrs_sched.sv
`timescale 1ns/1ps
module test_mrs_sched;
  localparam int NC = 4, SL = 8, DP = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]        ins_valid, ins_store, ins_full, ins_err;
  logic [3:0][4:0]   ins_reg;
  logic [3:0][15:0]  ins_addr;
  logic [3:0][5:0]   ins_id;
  logic [3:0][31:0]  ins_data;
  logic              open_valid, issue_valid, issue_ready, issue_store, issue_fwd;
  logic [7:0]        open_row;
  logic [4:0]        issue_slot, issue_reg;
  logic [15:0]       issue_addr;
  logic [5:0]        issue_id;
  logic [31:0]       issue_data;

  mrs_sched i_mrs_sched (
    .clk, .rst_n, .ins_valid, .ins_store, .ins_reg, .ins_addr, .ins_id, .ins_data,
    .ins_full, .ins_err, .open_valid, .open_row, .issue_valid, .issue_ready,
    .issue_slot, .issue_store, .issue_fwd, .issue_reg, .issue_addr, .issue_id,
    .issue_data
  );

  int checks = 0, errors = 0;

  // Reference model state
  bit        mv[DP], mst[DP], mfw[DP];
  int        mrg[DP], mad[DP], mid[DP], mage[DP];
  bit [31:0] mdt[DP];
  bit [DP-1:0] mdep[DP];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mhit(input int i);
    return open_valid && ((mad[i] >> 8) == int'(open_row));
  endfunction

  function automatic bit beats(input int i, input int w);
    if (mfw[i] != mfw[w]) return mfw[i];
    if (mhit(i) != mhit(w)) return mhit(i);
    return mage[i] > mage[w];
  endfunction

  function automatic void msel(output bit any, output int win);
    any = 0; win = 0;
    for (int i = 0; i < DP; i++)
      if (mv[i] && mdep[i] == 0 && (!any || beats(i, win))) begin
        any = 1; win = i;
      end
  endfunction

  function automatic bit merr(input int c);
    return ins_valid[c] && (int'(ins_addr[c][15:14]) != c);
  endfunction

  function automatic bit mfull(input int c);
    for (int k = 0; k < SL; k++) if (!mv[c*SL+k]) return 0;
    return 1;
  endfunction

  task automatic mstep(input bit fire, input int win);
    bit tk[NC]; int ns[NC]; bit nf[NC]; bit [31:0] nd[NC]; bit [DP-1:0] ndp[NC];
    for (int c = 0; c < NC; c++) begin
      int best;
      tk[c] = 0; ns[c] = 0; nf[c] = 0; nd[c] = 0; ndp[c] = 0;
      if (ins_valid[c] && !merr(c) && !mfull(c)) begin
        tk[c] = 1;
        for (int k = SL-1; k >= 0; k--) if (!mv[c*SL+k]) ns[c] = c*SL+k;
        best = -1;
        for (int i = c*SL; i < c*SL+SL; i++)
          if (mv[i] && mst[i] && !ins_store[c] && mad[i] == int'(ins_addr[c]) &&
              (best < 0 || mage[i] < mage[best])) best = i;
        nf[c] = best >= 0;
        nd[c] = nf[c] ? mdt[best] : ins_data[c];
        for (int i = c*SL; i < c*SL+SL; i++)
          if (mv[i] && !(fire && i == win)) begin
            bit raw, adh;
            raw = !mst[i] && mrg[i] == int'(ins_reg[c]);
            adh = mad[i] == int'(ins_addr[c]) && (ins_store[c] || mst[i]) && !nf[c];
            if (raw || adh) ndp[c][i] = 1;
          end
      end
    end
    for (int i = 0; i < DP; i++) if (mv[i] && mage[i] < 255) mage[i]++;
    if (fire) begin
      mv[win] = 0;
      for (int i = 0; i < DP; i++) mdep[i][win] = 0;
    end
    for (int c = 0; c < NC; c++)
      if (tk[c]) begin
        mv[ns[c]] = 1; mst[ns[c]] = ins_store[c]; mfw[ns[c]] = nf[c];
        mrg[ns[c]] = int'(ins_reg[c]); mad[ns[c]] = int'(ins_addr[c]);
        mid[ns[c]] = int'(ins_id[c]); mdt[ns[c]] = nd[c];
        mdep[ns[c]] = ndp[c]; mage[ns[c]] = 0;
      end
  endtask

  // Compare all outputs with the model, advance the model, move to next negedge.
  task automatic cycle();
    bit any; int win;
    #1;
    msel(any, win);
    chk(issue_valid == any, "R7", "issue_valid", issue_valid, any);
    if (any && issue_valid) begin
      chk(int'(issue_slot) == win, "R7", "issue_slot", issue_slot, win);
      chk(issue_fwd == mfw[win], "R8", "issue_fwd", issue_fwd, mfw[win]);
      chk(issue_store == mst[win], "R10", "issue_store", issue_store, mst[win]);
      chk(int'(issue_id) == mid[win], "R10", "issue_id", issue_id, mid[win]);
      if (mfw[win]) chk(issue_data == mdt[win], "R8", "issue_data", issue_data, mdt[win]);
    end
    for (int c = 0; c < NC; c++) begin
      chk(ins_full[c] == mfull(c), "R4", "ins_full", ins_full[c], mfull(c));
      chk(ins_err[c] == merr(c), "R3", "ins_err", ins_err[c], merr(c));
    end
    mstep(any && issue_ready, win);
    @(negedge clk);
  endtask

  task automatic put(input int c, input bit s, input int r, input int a, input bit [31:0] d);
    ins_valid[c] = 1'b1; ins_store[c] = s; ins_reg[c] = 5'(r);
    ins_addr[c] = 16'(a); ins_id[c] = 6'(c*8 + r); ins_data[c] = d;
  endtask

  task automatic clear_in();
    ins_valid = '0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #500us;
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    ins_valid = '0; ins_store = '0; ins_reg = '0; ins_addr = '0; ins_id = '0; ins_data = '0;
    open_valid = 1'b0; open_row = '0; issue_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(issue_valid == 1'b0, "R1", "issue_valid after reset", issue_valid, 0);
    chk(ins_full == 4'b0, "R1", "ins_full after reset", ins_full, 0);
    @(negedge clk);

    // R2 R9: two cores in one cycle, tie on age, then open row favours core 1
    put(0, 0, 1, 'h0010, 0); put(1, 0, 2, 'h4020, 0);
    cycle(); clear_in();
    #1 chk(issue_slot == 5'd0, "R2", "equal keys lowest slot", issue_slot, 0);
    open_valid = 1'b1; open_row = 8'h40;
    cycle();
    #1 chk(issue_slot == 5'd8, "R9", "row hit preferred", issue_slot, 8);
    issue_ready = 1'b1; cycle(); issue_ready = 1'b0;
    #1 chk(issue_slot == 5'd0, "R10", "taken entry left pool", issue_slot, 0);

    // R5 R6: same-register load waits despite its row hit
    put(0, 0, 1, 'h0200, 0);
    cycle(); clear_in();
    open_row = 8'h02;
    #1 chk(issue_slot == 5'd0, "R5", "dependent row hit held back", issue_slot, 0);
    issue_ready = 1'b1; cycle(); issue_ready = 1'b0;
    #1 chk(issue_slot == 5'd1, "R6", "released after producer left", issue_slot, 1);
    issue_ready = 1'b1; cycle(); issue_ready = 1'b0;

    // R8: load forwarded from pending store outranks the store's row hit
    put(2, 1, 4, 'h8040, 32'hDEAD_BEEF);
    cycle(); clear_in();
    put(2, 0, 5, 'h8040, 0);
    cycle(); clear_in();
    open_row = 8'h80;
    #1;
    chk(issue_slot == 5'd17 && issue_fwd, "R8", "forwarded load first", issue_slot, 17);
    chk(issue_data == 32'hDEAD_BEEF, "R8", "forwarded data", issue_data, 32'hDEAD_BEEF);
    issue_ready = 1'b1; cycle(); cycle(); issue_ready = 1'b0;
    #1 chk(issue_valid == 1'b0, "R6", "pool drained", issue_valid, 0);

    // R3: address outside the core's slice
    put(3, 0, 1, 'h0000, 0);
    #1 chk(ins_err[3] == 1'b1, "R3", "out of range flagged", ins_err[3], 1);
    cycle(); clear_in();
    #1 chk(issue_valid == 1'b0, "R3", "rejected request not stored", issue_valid, 0);
    put(3, 0, 1, 'hC000, 0);
    cycle(); clear_in();
    #1 chk(issue_slot == 5'd24, "R3", "slot 24 still free", issue_slot, 24);
    issue_ready = 1'b1; cycle(); issue_ready = 1'b0;

    // R4: fill core 1, post a ninth, drain eight
    open_valid = 1'b0;
    for (int k = 0; k < SL; k++) begin
      put(1, 0, k + 8, 'h4000 + k*4, 0);
      cycle(); clear_in();
    end
    #1 chk(ins_full[1] == 1'b1, "R4", "partition full", ins_full[1], 1);
    put(1, 0, 20, 'h4100, 0);
    cycle(); clear_in();
    issue_ready = 1'b1;
    repeat (SL) cycle();
    issue_ready = 1'b0;
    #1 chk(issue_valid == 1'b0, "R4", "request while full dropped", issue_valid, 0);

    // R11: older entry wins, then saturated ages tie and lowest slot wins
    put(1, 0, 1, 'h4000, 0);
    cycle(); clear_in();
    cycle();
    put(0, 0, 1, 'h0000, 0);
    cycle(); clear_in();
    #1 chk(issue_slot == 5'd8, "R11", "older entry first", issue_slot, 8);
    repeat (300) cycle();
    #1 chk(issue_slot == 5'd0, "R11", "saturated ages tie", issue_slot, 0);
    issue_ready = 1'b1; cycle(); cycle(); issue_ready = 1'b0;

    // Random traffic with frequent address and register collisions
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NC; c++) begin
        ins_valid[c] = ($urandom % 3) == 0;
        ins_store[c] = $urandom % 2;
        ins_reg[c]   = 5'($urandom % 4);
        ins_addr[c]  = {(($urandom % 10) == 0) ? 2'($urandom) : 2'(c),
                        6'($urandom % 3), 8'($urandom % 4)};
        ins_id[c]    = 6'($urandom);
        ins_data[c]  = $urandom;
      end
      issue_ready = $urandom % 2;
      open_valid  = ($urandom % 4) != 0;
      open_row    = {2'($urandom % 4), 6'($urandom % 3)};
      cycle();
    end
    clear_in();
    issue_ready = 1'b1;
    repeat (200) cycle();
    #1 chk(issue_valid == 1'b0, "R6", "random traffic drains", issue_valid, 0);

    summary();
    $finish;
  end
endmodule